// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block drives a serial EEPROM over four pins: a select line, a serial clock, a command/data line into the memory and a data line back out of it. A client asks for one 16-bit word with a single-cycle `start`, a direction bit, a byte offset and (for writes) the data. The block halves the offset into a word address and builds every frame itself. A read is one frame: a read opcode, the address, then sixteen bits clocked back in. A write is a longer sequence: a write-enable frame, the write frame, a fixed programming wait counted in system clocks, a write-disable frame and a final cleanup pulse.

The serial clock is made from the system clock by a parameterised divider. The number of address bits the memory expects is a runtime input, so one netlist can serve parts of several sizes. Some memory parts want one extra clock pulse after select before the first command bit, and a configuration input adds it. The serial clock pin is shared with another function on the board. For that reason `busy` covers the whole access, and `restore` pulses once when the pin is handed back.

Top module: `mw_eeprom_master`

## Requirements
- R1: The word address sent is `offset >> 1`, limited to its low `addr_bits` bits. Offset bit 0 and any bit above the address field have no effect on the frame.
- R2: Each frame begins with `ee_sel` raised while `ee_clk` and `ee_txd` are low. When `dummy_en` is 1, exactly one clock pulse with `ee_txd` low is given before the start bit. When `dummy_en` is 0, no pulse comes before the start bit.
- R3: A read frame sends 3'b110 and then the address, each MSB first. It then gives sixteen more clock pulses. `ee_rxd` is sampled while the clock is high after each rising edge, and the samples are assembled MSB first into `rdata`.
- R4: A write runs three frames in this order. The first is the enable frame 5'b10011 followed by six zeros. The second is 3'b101, then the address, then the 16 data bits, all MSB first. The third is the disable frame 5'b10000 followed by six zeros.
- R5: `ee_txd` is low whenever `ee_sel` is low, and it goes low after the last bit of every frame.
- R6: Every frame ends with a cleanup: `ee_sel` and `ee_txd` low, then one full clock pulse. A write adds one more cleanup pulse after the disable frame. So a read gives 1 pulse with select low, and a write gives 4.
- R7: `busy` is high from the cycle after an accepted `start` until completion. `ee_sel` and `ee_clk` are high only while `busy` is high. After reset all outputs are 0.
- R8: `done` and `restore` each pulse for one cycle at completion, in the cycle in which `busy` falls.
- R9: `start` is ignored while `busy` is high. `rdata` changes only during a read access and otherwise keeps its last value.
- R10: Between the select fall of the write frame and the select rise of the disable frame, at least `PROG_CYCLES` system clocks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request, taken only when idle |
| wr | input | 1 | 1 = word write, 0 = word read |
| offset | input | AW_MAX+1 | Byte offset of the word |
| wdata | input | 16 | Word to write |
| addr_bits | input | clog2(AW_MAX+1) | Address bits expected by the memory (1..AW_MAX) |
| dummy_en | input | 1 | Add one clock pulse after select |
| ee_sel | output | 1 | Memory chip select |
| ee_clk | output | 1 | Serial clock (shared pin) |
| ee_txd | output | 1 | Serial line into the memory |
| ee_rxd | input | 1 | Serial line from the memory |
| rdata | output | 16 | Last word read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress; other users keep off the clock pin |
| restore | output | 1 | One-cycle pulse handing the clock pin back |

## Verification
The assertions assume that `addr_bits` and `dummy_en` hold still for the whole of an access, and that `addr_bits` lies between 1 and `AW_MAX`. They also assume the memory changes `ee_rxd` only on rising serial clock edges. The bench changes the configuration only between accesses, uses address widths of 4 and 6, and models the memory so that it updates its output line on the rising clock edge. The model also recognises frames by their start bit, so a dummy pulse shows up as a counted leading zero rather than as corrupted data.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

    localparam int WORD_W   = 16;
    localparam int SUFFIX_W = 6;

    // command codes, start bit included
    localparam logic [2:0] OP_RD  = 3'b110;
    localparam logic [2:0] OP_WR  = 3'b101;
    localparam logic [4:0] OP_EN  = 5'b10011;
    localparam logic [4:0] OP_DIS = 5'b10000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_DUMMY,
        ST_OUT,
        ST_IN,
        ST_CLEAN,
        ST_WAIT
    } mw_step_e;

    typedef enum logic [1:0] {
        FR_EN,
        FR_WR,
        FR_DIS,
        FR_RD
    } mw_frame_e;

endpackage

// File: rtl/mw_tick_gen.sv
`timescale 1ns/1ps
module mw_tick_gen #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(HALF_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == TW'(HALF_CYCLES - 1));
        cnt_d = cnt_q + TW'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mw_prog_timer.sv
`timescale 1ns/1ps
module mw_prog_timer #(
    parameter int CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int PW = $clog2(CYCLES + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = (cnt_q == '0);
        cnt_d   = cnt_q;
        if (arm) begin
            cnt_d = PW'(CYCLES);
        end else if (!expired) begin
            cnt_d = cnt_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= PW'(CYCLES);
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mw_eeprom_master.sv
`timescale 1ns/1ps
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int AW_MAX      = 8,
    parameter int HALF_CYCLES = 4,
    parameter int PROG_CYCLES = 2000000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       wr,
    input  logic [AW_MAX:0]            offset,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [$clog2(AW_MAX+1)-1:0] addr_bits,
    input  logic                       dummy_en,
    output logic                       ee_sel,
    output logic                       ee_clk,
    output logic                       ee_txd,
    input  logic                       ee_rxd,
    output logic [WORD_W-1:0]          rdata,
    output logic                       done,
    output logic                       busy,
    output logic                       restore
);
    localparam int ABW  = $clog2(AW_MAX + 1);
    localparam int SH_W = 3 + AW_MAX + WORD_W;
    localparam int CW   = $clog2(SH_W + 1);
    localparam int CTL_LEN = 5 + SUFFIX_W;

    typedef struct packed {
        mw_step_e            step;
        mw_frame_e           frame;
        logic                hi;
        logic                second;
        logic                cs;
        logic                sck;
        logic                di;
        logic [SH_W-1:0]     sh;
        logic [CW-1:0]       cnt;
        logic [AW_MAX-1:0]   addr;
        logic [WORD_W-1:0]   wd;
        logic [WORD_W-1:0]   rd;
        logic                busy;
        logic                done;
        logic                restore;
    } st_t;

    st_t q, d;

    logic tick;
    logic expired;

    mw_tick_gen #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.busy),
        .tick  (tick)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (q.step != ST_WAIT),
        .expired (expired)
    );

    // word address: halve the byte offset, keep addr_bits low bits
    logic [AW_MAX-1:0] word_addr;
    always_comb begin
        word_addr = offset[AW_MAX:1] & ~({AW_MAX{1'b1}} << addr_bits);
    end

    // frame contents, left justified in the shift register
    logic [SH_W-1:0] fr_raw;
    logic [SH_W-1:0] fr_vec;
    logic [CW-1:0]   fr_len;
    always_comb begin
        fr_raw = '0;
        fr_len = CW'(CTL_LEN);
        unique case (q.frame)
            FR_EN: begin
                fr_raw = SH_W'({OP_EN, {SUFFIX_W{1'b0}}});
                fr_len = CW'(CTL_LEN);
            end
            FR_DIS: begin
                fr_raw = SH_W'({OP_DIS, {SUFFIX_W{1'b0}}});
                fr_len = CW'(CTL_LEN);
            end
            FR_WR: begin
                fr_raw = (SH_W'(OP_WR) << (CW'(addr_bits) + CW'(WORD_W)))
                       | (SH_W'(q.addr) << WORD_W)
                       | SH_W'(q.wd);
                fr_len = CW'(addr_bits) + CW'(3 + WORD_W);
            end
            FR_RD: begin
                fr_raw = (SH_W'(OP_RD) << CW'(addr_bits)) | SH_W'(q.addr);
                fr_len = CW'(addr_bits) + CW'(3);
            end
            default: begin
                fr_raw = '0;
                fr_len = CW'(CTL_LEN);
            end
        endcase
        fr_vec = fr_raw << (CW'(SH_W) - fr_len);
    end

    logic [SH_W-1:0] sh_next;
    always_comb begin
        sh_next = q.sh << 1;
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.restore = 1'b0;

        unique case (q.step)
            ST_IDLE: begin
                if (start) begin
                    d.addr   = word_addr;
                    d.wd     = wdata;
                    d.frame  = wr ? FR_EN : FR_RD;
                    d.step   = ST_SEL;
                    d.cs     = 1'b1;
                    d.sck    = 1'b0;
                    d.di     = 1'b0;
                    d.hi     = 1'b0;
                    d.second = 1'b0;
                    d.busy   = 1'b1;
                end
            end

            ST_SEL: begin
                if (tick) begin
                    d.sh  = fr_vec;
                    d.cnt = fr_len;
                    d.hi  = 1'b0;
                    if (dummy_en) begin
                        d.step = ST_DUMMY;
                    end else begin
                        d.step = ST_OUT;
                        d.di   = fr_vec[SH_W-1];
                    end
                end
            end

            ST_DUMMY: begin
                if (tick) begin
                    if (!q.hi) begin
                        d.sck = 1'b1;
                        d.hi  = 1'b1;
                    end else begin
                        d.sck  = 1'b0;
                        d.hi   = 1'b0;
                        d.step = ST_OUT;
                        d.di   = q.sh[SH_W-1];
                    end
                end
            end

            ST_OUT: begin
                if (tick) begin
                    if (!q.hi) begin
                        d.sck = 1'b1;
                        d.hi  = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        d.hi  = 1'b0;
                        d.sh  = sh_next;
                        d.cnt = q.cnt - CW'(1);
                        if (q.cnt == CW'(1)) begin
                            d.di = 1'b0;
                            if (q.frame == FR_RD) begin
                                d.step = ST_IN;
                                d.cnt  = CW'(WORD_W);
                            end else begin
                                d.step = ST_CLEAN;
                                d.cs   = 1'b0;
                            end
                        end else begin
                            d.di = sh_next[SH_W-1];
                        end
                    end
                end
            end

            ST_IN: begin
                if (tick) begin
                    if (!q.hi) begin
                        d.sck = 1'b1;
                        d.hi  = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        d.hi  = 1'b0;
                        d.rd  = {q.rd[WORD_W-2:0], ee_rxd};
                        d.cnt = q.cnt - CW'(1);
                        if (q.cnt == CW'(1)) begin
                            d.step = ST_CLEAN;
                            d.cs   = 1'b0;
                        end
                    end
                end
            end

            ST_CLEAN: begin
                d.cs = 1'b0;
                d.di = 1'b0;
                if (tick) begin
                    if (!q.hi) begin
                        d.sck = 1'b1;
                        d.hi  = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        d.hi  = 1'b0;
                        unique case (q.frame)
                            FR_EN: begin
                                d.frame = FR_WR;
                                d.step  = ST_SEL;
                                d.cs    = 1'b1;
                            end
                            FR_WR: begin
                                d.step = ST_WAIT;
                            end
                            FR_DIS: begin
                                if (!q.second) begin
                                    d.second = 1'b1;
                                end else begin
                                    d.step    = ST_IDLE;
                                    d.busy    = 1'b0;
                                    d.done    = 1'b1;
                                    d.restore = 1'b1;
                                end
                            end
                            default: begin
                                d.step    = ST_IDLE;
                                d.busy    = 1'b0;
                                d.done    = 1'b1;
                                d.restore = 1'b1;
                            end
                        endcase
                    end
                end
            end

            ST_WAIT: begin
                if (expired) begin
                    d.frame  = FR_DIS;
                    d.step   = ST_SEL;
                    d.cs     = 1'b1;
                    d.hi     = 1'b0;
                    d.second = 1'b0;
                end
            end

            default: begin
                d.step = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{step: ST_IDLE, frame: FR_RD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ee_sel  = q.cs;
    assign ee_clk  = q.sck;
    assign ee_txd  = q.di;
    assign rdata   = q.rd;
    assign done    = q.done;
    assign busy    = q.busy;
    assign restore = q.restore;

endmodule

// File: rtl/mw_eeprom_master_chk.sv
`timescale 1ns/1ps
module mw_eeprom_master_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              restore,
    input logic              ee_sel,
    input logic              ee_clk,
    input logic              ee_txd,
    input logic [WORD_W-1:0] rdata
);
    p_sel_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sel |-> busy);

    p_clk_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ee_clk |-> busy);

    p_txd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_sel |-> !ee_txd);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_restore_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> $fell(busy));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> $stable(rdata));
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.WORD_W(16)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .restore (restore),
    .ee_sel  (ee_sel),
    .ee_clk  (ee_clk),
    .ee_txd  (ee_txd),
    .rdata   (rdata)
);

// File: tb/mw_eeprom_master_tb.sv
`timescale 1ns/1ps
module mw_eeprom_master_tb;
    localparam int AW_MAX = 8;
    localparam int HALF   = 2;
    localparam int PROG   = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [AW_MAX:0] offset = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  addr_bits = 4'd4;
    logic        dummy_en = 1'b0;
    logic        ee_sel, ee_clk, ee_txd;
    logic        ee_rxd = 1'b0;
    logic [15:0] rdata;
    logic        done, busy, restore;

    always #2.5 clk = ~clk;

    mw_eeprom_master #(.AW_MAX(AW_MAX), .HALF_CYCLES(HALF), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .offset(offset),
        .wdata(wdata), .addr_bits(addr_bits), .dummy_en(dummy_en),
        .ee_sel(ee_sel), .ee_clk(ee_clk), .ee_txd(ee_txd), .ee_rxd(ee_rxd),
        .rdata(rdata), .done(done), .busy(busy), .restore(restore)
    );

    int n_chk = 0;
    int n_err = 0;
    int ab = 4;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc++;

    // ---------------- memory model ----------------
    logic [15:0] mem [256];
    logic [15:0] expm [256];
    bit          wen = 0;
    bit          m_started = 0;
    bit          m_rd = 0;
    int          m_lead = 0;
    int          m_nb = 0;
    int          m_idx = 0;
    logic [63:0] m_fb = '0;
    logic [15:0] m_word = '0;

    int          f_cnt = 0;
    int          r_cnt = 0;
    int          n_clean = 0;
    int          f_nb   [8];
    logic [63:0] f_bits [8];
    int          f_lead [8];
    int          f_fall [8];
    int          f_rise [8];

    always @(posedge ee_clk or negedge ee_sel) begin
        if (!ee_sel) begin
            if (m_started) begin
                if (f_cnt < 8) begin
                    f_nb[f_cnt]   = m_nb;
                    f_bits[f_cnt] = m_fb;
                    f_lead[f_cnt] = m_lead;
                    f_fall[f_cnt] = cyc;
                    f_cnt++;
                end
                if (m_nb == 10 && m_fb[9:0] == 10'b0011000000) wen = 1;
                else if (m_nb == 10 && m_fb[9:0] == 10'b0) wen = 0;
                else if (m_nb == 2 + ab + 16 && ((m_fb >> (ab + 16)) & 64'd3) == 64'd1 && wen)
                    mem[int'((m_fb >> 16) & ((64'd1 << ab) - 1))] = m_fb[15:0];
            end
            m_started = 0; m_lead = 0; m_nb = 0; m_fb = '0; m_rd = 0; ee_rxd = 1'b0;
        end else begin
            if (!m_started) begin
                if (ee_txd) m_started = 1;
                else m_lead++;
            end else begin
                m_fb = {m_fb[62:0], ee_txd};
                m_nb++;
                if (m_nb == 2 + ab && ((m_fb >> ab) & 64'd3) == 64'd2) begin
                    m_rd = 1;
                    m_word = mem[int'(m_fb & ((64'd1 << ab) - 1))];
                    m_idx = 0;
                    ee_rxd = 1'b0;
                end else if (m_rd && m_nb > 2 + ab && m_idx < 16) begin
                    ee_rxd = m_word[15 - m_idx];
                    m_idx++;
                end
            end
        end
    end

    always @(posedge ee_clk) if (!ee_sel) n_clean++;
    always @(posedge ee_sel) begin
        if (r_cnt < 8) f_rise[r_cnt] = cyc;
        r_cnt++;
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_access(input bit w, input int off, input logic [15:0] dt,
                              input bit dmy, input bit poke);
        int bad;
        int k;
        f_cnt = 0; r_cnt = 0; n_clean = 0;
        @(negedge clk);
        start = 1'b1; wr = w; offset = (AW_MAX+1)'(off); wdata = dt; dummy_en = dmy;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after start", busy, 1);
        bad = 0; k = 0;
        while (!done) begin
            if (!busy) bad++;
            start = poke && (k == 12);
            if (poke && k == 12) begin
                offset = (AW_MAX+1)'(off ^ 2);
                wr = ~w;
            end
            k++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad == 0, "R7", "busy held through access", bad, 0);
        chk(restore == 1'b1 && busy == 1'b0, "R8", "restore with done, busy low",
            {restore, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0 && restore == 1'b0, "R8", "single-cycle pulses", {done, restore}, 0);
        chk({ee_sel, ee_clk, ee_txd} == 3'b000, "R5", "pins quiet after access",
            {ee_sel, ee_clk, ee_txd}, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(busy == 1'b0, "R9", "start during access ignored (no new access)", busy, 0);
        end
    endtask

    task automatic do_read(input int off, input bit dmy, input bit poke);
        int wa;
        longint mask;
        mask = (64'd1 << ab) - 1;
        wa = (off >> 1) & int'(mask);
        run_access(1'b0, off, 16'h0, dmy, poke);
        chk(f_cnt == 1, "R3", "read frame count", f_cnt, 1);
        chk(f_nb[0] == 2 + ab + 16, "R3", "read frame clocks", f_nb[0], 2 + ab + 16);
        chk(((f_bits[0] >> (ab + 16)) & 3) == 2, "R3", "read opcode",
            (f_bits[0] >> (ab + 16)) & 3, 2);
        chk(((f_bits[0] >> 16) & mask) == wa, "R1", "read word address",
            (f_bits[0] >> 16) & mask, wa);
        chk(f_lead[0] == int'(dmy), "R2", "pulses before start bit", f_lead[0], dmy);
        chk(rdata == expm[wa], "R3", "read data", rdata, expm[wa]);
        chk(n_clean == 1, "R6", "cleanup pulses of read", n_clean, 1);
    endtask

    task automatic do_write(input int off, input logic [15:0] dt, input bit dmy, input bit poke);
        int wa;
        longint mask;
        longint expf;
        logic [15:0] rd_before;
        mask = (64'd1 << ab) - 1;
        wa = (off >> 1) & int'(mask);
        rd_before = rdata;
        run_access(1'b1, off, dt, dmy, poke);
        expm[wa] = dt;
        expf = (64'd1 << (ab + 16)) | (longint'(wa) << 16) | longint'(dt);
        chk(f_cnt == 3, "R4", "write frame count", f_cnt, 3);
        chk(f_nb[0] == 10 && f_bits[0][9:0] == 10'b0011000000, "R4", "enable frame",
            f_bits[0][9:0], 10'b0011000000);
        chk(f_nb[1] == 2 + ab + 16, "R4", "write frame clocks", f_nb[1], 2 + ab + 16);
        chk((f_bits[1] & ((64'd1 << (ab + 18)) - 1)) == expf, "R4", "write frame bits",
            f_bits[1] & ((64'd1 << (ab + 18)) - 1), expf);
        chk(((f_bits[1] >> 16) & mask) == wa, "R1", "write word address",
            (f_bits[1] >> 16) & mask, wa);
        chk(f_nb[2] == 10 && f_bits[2][9:0] == 10'b0, "R4", "disable frame",
            f_bits[2][9:0], 0);
        chk(f_lead[0] == int'(dmy) && f_lead[1] == int'(dmy) && f_lead[2] == int'(dmy),
            "R2", "pulses before start bits", f_lead[1], dmy);
        chk(n_clean == 4, "R6", "cleanup pulses of write", n_clean, 4);
        chk(f_rise[2] - f_fall[1] >= PROG, "R10", "programming wait",
            f_rise[2] - f_fall[1], PROG);
        chk(rdata == rd_before, "R9", "rdata kept during write", rdata, rd_before);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 16'(i * 7919 + 3);
            expm[i] = 16'(i * 7919 + 3);
        end
        repeat (4) @(negedge clk);
        chk({busy, done, restore, ee_sel, ee_clk, ee_txd} == 6'b0 && rdata == 16'h0,
            "R7", "reset state", {busy, done, restore, ee_sel, ee_clk, ee_txd}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int pass = 0; pass < 2; pass++) begin
            ab = (pass == 0) ? 4 : 6;
            addr_bits = 4'(ab);
            // fill every word
            for (int w = 0; w < (1 << ab); w++)
                do_write(w * 2 + (w & 1), 16'(w * 40503 + ab * 911 + 16'h1234), w[1], 1'b0);
            // read back, odd offsets and an out-of-range high bit
            for (int w = 0; w < (1 << ab); w++)
                do_read((w * 2) | ((w & 2) != 0 ? 1 : 0) | ((w & 4) != 0 ? (1 << (ab + 1)) : 0),
                        ~w[0], 1'b0);
            // start pulses during busy accesses
            do_write(6, 16'hA5C3, 1'b1, 1'b1);
            do_read(6, 1'b0, 1'b1);
            do_read(7, 1'b1, 1'b0);
            // rdata holds while idle
            begin
                logic [15:0] keep;
                keep = rdata;
                repeat (50) @(negedge clk);
                chk(rdata == keep, "R9", "rdata stable while idle", rdata, keep);
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule